// File: doc/BRIEF.md
# Complementary Pair Deadtime Generator

This block turns a PWM reference into the top and bottom drive signals of one half-bridge leg. In complementary mode, an edge on the reference turns off the output that is on. The other output is turned on only after a programmable number of clock cycles in which both outputs stay off. This gap keeps the two switches of the leg from conducting together. A mode input can instead release the pair as two independent outputs. Each output then follows its own PWM input. Several instances, each with its own mode input, give any mix from all-complementary pairs to all-independent channels.

The block receives two candidate references, each generated from its own duty value. A correction selector picks which of the two drives the pair, which is how current-sense distortion correction is applied. The selector takes its choice either from a current-status input or from a software bit. Polarity is applied per output after deadtime insertion, so each output can be active-high or active-low and the off intervals stay intact.

The core is a five-state machine:
- BOT_ON: the bottom output is on.
- GAP_UP: both outputs are off while counting toward turning the top output on.
- TOP_ON: the top output is on.
- GAP_DN: both outputs are off while counting toward turning the bottom output on.
- SPLIT: independent mode.

Its transitions are:
- BOT_ON→GAP_UP or TOP_ON→GAP_DN when the reference changes and the deadtime is nonzero.
- BOT_ON→TOP_ON or TOP_ON→BOT_ON directly when the deadtime is zero.
- GAP_UP→TOP_ON or GAP_DN→BOT_ON when the count reaches the deadtime.
- GAP_UP→GAP_DN or GAP_DN→GAP_UP (restart) when the reference reverses during a gap.
- any→SPLIT while the mode input is high.
- SPLIT→GAP_UP, GAP_DN, TOP_ON or BOT_ON when the mode input is released.

Top module: `dtp_pair_top`

## Requirements
- R1: While reset is low, and right after it is released, both outputs are inactive. With the reference low and deadtime D, the bottom output becomes active on the (D+1)th rising clock edge after reset release.
- R2: In complementary mode (indep_i=0), the active-high internal top and bottom signals are never both asserted. The top output is on while the selected reference is high, and the bottom output is on while it is low.
- R3: Deadtime D (dead_i>0) is measured from the first rising edge that samples a new reference level. Both outputs are inactive on the following D edges, and the newly active output turns on at edge D+1.
- R4: A reversal of the reference during a gap restarts the count toward the other output. A reference pulse that lasts at most D sampled edges never turns on the output it would activate.
- R5: With dead_i=0, the outputs swap one clock edge after the reference changes, with no cycle in which both are inactive.
- R6: With indep_i=1, top follows ref_a_i and bottom follows ref_b_i with one cycle of latency. Both outputs may be active together.
- R7: With pol_top_i=1 or pol_bot_i=1, the corresponding output is active-low and drives 1 while inactive. This includes the deadtime gap.
- R8: The correction source is corr_cs_i when corr_src_i=1 and corr_sw_i when corr_src_i=0. A selected value of 0 makes ref_a_i drive the pair, and a selected value of 1 makes ref_b_i drive it. The unselected bit has no effect.
- R9: When indep_i falls, both outputs become inactive for D cycles before the output chosen by the reference turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_a_i | input | 1 | PWM reference from the first duty value; top input in independent mode |
| ref_b_i | input | 1 | PWM reference from the second duty value; bottom input in independent mode |
| dead_i | input | DT_W | Deadtime in clock cycles |
| indep_i | input | 1 | 1 = independent outputs, 0 = complementary pair |
| pol_top_i | input | 1 | 1 = top output active-low |
| pol_bot_i | input | 1 | 1 = bottom output active-low |
| corr_src_i | input | 1 | 1 = correction from the current-status input, 0 = from the software bit |
| corr_sw_i | input | 1 | Software correction bit |
| corr_cs_i | input | 1 | Current-status correction input |
| top_o | output | 1 | Top switch drive |
| bot_o | output | 1 | Bottom switch drive |

## Verification
The following reference patterns are applied in complementary mode:
- Long steady pulses with a nonzero deadtime, which measure the exact gap on each edge direction.
- A pulse of exactly D edges next to one of D+1 edges, which separates suppression of a short pulse from an off-by-one error in the count.
- Single-cycle toggles with zero deadtime, which expose any spurious gap cycle.

Inverted polarity is tried during a gap, which shows whether inversion happens after the gap logic. Independent patterns with both inputs high prove the outputs are released from the complementary rule. The correction select is exercised from both sources, with the unselected bit set opposite, so that a wrong source pick changes which output is on.

// File: rtl/dtp_pkg.sv
package dtp_pkg;

    typedef enum logic [2:0] {
        ST_BOT_ON = 3'd0,
        ST_GAP_UP = 3'd1,
        ST_TOP_ON = 3'd2,
        ST_GAP_DN = 3'd3,
        ST_SPLIT  = 3'd4
    } pair_state_e;

    localparam int unsigned NUM_OUT = 2;
    localparam int unsigned IDX_TOP = 0;
    localparam int unsigned IDX_BOT = 1;

endpackage

// File: rtl/dtp_ref_select.sv
module dtp_ref_select (
    input  logic ref_a_i,
    input  logic ref_b_i,
    input  logic corr_src_i,
    input  logic corr_sw_i,
    input  logic corr_cs_i,
    output logic ref_sel_o
);

    logic pick_b;

    always_comb begin
        pick_b    = corr_src_i ? corr_cs_i : corr_sw_i;
        ref_sel_o = pick_b ? ref_b_i : ref_a_i;
    end

endmodule

// File: rtl/dtp_dead_fsm.sv
module dtp_dead_fsm
    import dtp_pkg::*;
#(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_i,
    input  logic            split_a_i,
    input  logic            split_b_i,
    input  logic            indep_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            act_top_o,
    output logic            act_bot_o
);

    localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

    pair_state_e     st_q, st_n;
    logic [DT_W-1:0] cnt_q, cnt_n;
    logic            split_a_q, split_b_q;
    logic            dead_zero;

    assign dead_zero = (dead_i == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_GAP_DN;
            cnt_q     <= '0;
            split_a_q <= 1'b0;
            split_b_q <= 1'b0;
        end else begin
            st_q      <= st_n;
            cnt_q     <= cnt_n;
            split_a_q <= split_a_i;
            split_b_q <= split_b_i;
        end
    end

    // next state
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (indep_i) begin
            st_n = ST_SPLIT;
        end else begin
            unique case (st_q)
                ST_TOP_ON: begin
                    if (!ref_i) begin
                        if (dead_zero) begin
                            st_n = ST_BOT_ON;
                        end else begin
                            st_n  = ST_GAP_DN;
                            cnt_n = CNT_ONE;
                        end
                    end
                end
                ST_BOT_ON: begin
                    if (ref_i) begin
                        if (dead_zero) begin
                            st_n = ST_TOP_ON;
                        end else begin
                            st_n  = ST_GAP_UP;
                            cnt_n = CNT_ONE;
                        end
                    end
                end
                ST_GAP_UP: begin
                    if (!ref_i) begin
                        if (dead_zero) begin
                            st_n = ST_BOT_ON;
                        end else begin
                            st_n  = ST_GAP_DN;
                            cnt_n = CNT_ONE;
                        end
                    end else if (cnt_q >= dead_i) begin
                        st_n = ST_TOP_ON;
                    end else begin
                        cnt_n = cnt_q + CNT_ONE;
                    end
                end
                ST_GAP_DN: begin
                    if (ref_i) begin
                        if (dead_zero) begin
                            st_n = ST_TOP_ON;
                        end else begin
                            st_n  = ST_GAP_UP;
                            cnt_n = CNT_ONE;
                        end
                    end else if (cnt_q >= dead_i) begin
                        st_n = ST_BOT_ON;
                    end else begin
                        cnt_n = cnt_q + CNT_ONE;
                    end
                end
                ST_SPLIT: begin
                    cnt_n = CNT_ONE;
                    if (ref_i) begin
                        st_n = dead_zero ? ST_TOP_ON : ST_GAP_UP;
                    end else begin
                        st_n = dead_zero ? ST_BOT_ON : ST_GAP_DN;
                    end
                end
                default: begin
                    st_n  = ST_GAP_DN;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        act_top_o = 1'b0;
        act_bot_o = 1'b0;
        unique case (st_q)
            ST_TOP_ON: act_top_o = 1'b1;
            ST_BOT_ON: act_bot_o = 1'b1;
            ST_SPLIT: begin
                act_top_o = split_a_q;
                act_bot_o = split_b_q;
            end
            default: begin
                act_top_o = 1'b0;
                act_bot_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dtp_polarity.sv
module dtp_polarity #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] act_i,
    input  logic [N-1:0] pol_i,
    output logic [N-1:0] drv_o
);

    for (genvar g = 0; g < N; g++) begin : g_pol
        assign drv_o[g] = act_i[g] ^ pol_i[g];
    end

endmodule

// File: rtl/dtp_pair_top.sv
module dtp_pair_top
    import dtp_pkg::*;
#(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_a_i,
    input  logic            ref_b_i,
    input  logic [DT_W-1:0] dead_i,
    input  logic            indep_i,
    input  logic            pol_top_i,
    input  logic            pol_bot_i,
    input  logic            corr_src_i,
    input  logic            corr_sw_i,
    input  logic            corr_cs_i,
    output logic            top_o,
    output logic            bot_o
);

    logic               ref_sel;
    logic               act_top, act_bot;
    logic [NUM_OUT-1:0] act_vec, pol_vec, drv_vec;

    dtp_ref_select u_sel (
        .ref_a_i    (ref_a_i),
        .ref_b_i    (ref_b_i),
        .corr_src_i (corr_src_i),
        .corr_sw_i  (corr_sw_i),
        .corr_cs_i  (corr_cs_i),
        .ref_sel_o  (ref_sel)
    );

    dtp_dead_fsm #(.DT_W(DT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_i     (ref_sel),
        .split_a_i (ref_a_i),
        .split_b_i (ref_b_i),
        .indep_i   (indep_i),
        .dead_i    (dead_i),
        .act_top_o (act_top),
        .act_bot_o (act_bot)
    );

    always_comb begin
        act_vec[IDX_TOP] = act_top;
        act_vec[IDX_BOT] = act_bot;
        pol_vec[IDX_TOP] = pol_top_i;
        pol_vec[IDX_BOT] = pol_bot_i;
    end

    dtp_polarity #(.N(NUM_OUT)) u_pol (
        .act_i (act_vec),
        .pol_i (pol_vec),
        .drv_o (drv_vec)
    );

    assign top_o = drv_vec[IDX_TOP];
    assign bot_o = drv_vec[IDX_BOT];

endmodule

// File: rtl/dtp_pair_checker.sv
module dtp_pair_checker #(
    parameter int unsigned DT_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            indep_i,
    input logic            ref_a_i,
    input logic            ref_sel,
    input logic [DT_W-1:0] dead_i,
    input logic            act_top,
    input logic            act_bot
);

    // R2: no overlap in complementary mode
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(indep_i)) |-> !(act_top && act_bot));

    // R3: top turns on only after the reference was high
    a_r3_top_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(indep_i) && $rose(act_top)) |-> $past(ref_sel));

    // R3: bottom turns on only after the reference was low
    a_r3_bot_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(indep_i) && $rose(act_bot)) |-> !$past(ref_sel));

    // R5: zero deadtime leaves no gap
    a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(indep_i) && ($past(dead_i) == '0) && $past(act_top || act_bot))
        |-> (act_top || act_bot));

    // R6: independent top follows its input
    a_r6_split_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(indep_i) && indep_i) |-> (act_top == $past(ref_a_i)));

endmodule

bind dtp_pair_top dtp_pair_checker #(.DT_W(DT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .indep_i (indep_i),
    .ref_a_i (ref_a_i),
    .ref_sel (ref_sel),
    .dead_i  (dead_i),
    .act_top (act_top),
    .act_bot (act_bot)
);

// File: tb/dtp_pair_top_bench.sv
module dtp_pair_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DT_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ref_a_i = 1'b0, ref_b_i = 1'b0;
    logic [DT_W-1:0] dead_i = 8'd3;
    logic            indep_i = 1'b0;
    logic            pol_top_i = 1'b0, pol_bot_i = 1'b0;
    logic            corr_src_i = 1'b0, corr_sw_i = 1'b0, corr_cs_i = 1'b0;
    logic            top_o, bot_o;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtp_pair_top #(.DT_W(DT_W)) u_dtp_pair_top (
        .clk(clk), .rst_n(rst_n), .ref_a_i(ref_a_i), .ref_b_i(ref_b_i),
        .dead_i(dead_i), .indep_i(indep_i), .pol_top_i(pol_top_i),
        .pol_bot_i(pol_bot_i), .corr_src_i(corr_src_i), .corr_sw_i(corr_sw_i),
        .corr_cs_i(corr_cs_i), .top_o(top_o), .bot_o(bot_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [1:0] exp);
        checks++;
        if ({top_o, bot_o} !== exp) begin
            errors++;
            $display("FAIL %s: {top,bot} actual=%b expected=%b at %0t",
                     req, {top_o, bot_o}, exp, $time);
        end
    endtask

    task automatic t_reset;
        tick(2);
        chk("R1 in reset", 2'b00);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick(1);
            chk("R1 gap after reset", 2'b00);
        end
        tick(1);
        chk("R1 bottom on", 2'b01);
    endtask

    task automatic t_deadtime;
        dead_i  = 8'd3;
        ref_a_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick(1);
            chk("R3 rise gap", 2'b00);
        end
        tick(1);
        chk("R3 top on / R2", 2'b10);
        tick(2);
        chk("R2 top steady", 2'b10);
        ref_a_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick(1);
            chk("R3 fall gap", 2'b00);
        end
        tick(1);
        chk("R3 bottom on / R2", 2'b01);
    endtask

    task automatic t_short;
        dead_i  = 8'd4;
        ref_a_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            chk("R4 short pulse top held", 2'b00);
        end
        ref_a_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            chk("R4 restart gap", 2'b00);
        end
        tick(1);
        chk("R4 bottom after restart", 2'b01);
        ref_a_i = 1'b1;
        tick(4);
        chk("R4 pulse D+1 still gap", 2'b00);
        tick(1);
        chk("R4 pulse D+1 top on", 2'b10);
        ref_a_i = 1'b0;
        tick(5);
        chk("R4 settle bottom", 2'b01);
    endtask

    task automatic t_zero;
        dead_i = 8'd0;
        for (int i = 0; i < 3; i++) begin
            ref_a_i = 1'b1;
            tick(1);
            chk("R5 swap to top", 2'b10);
            ref_a_i = 1'b0;
            tick(1);
            chk("R5 swap to bottom", 2'b01);
        end
    endtask

    task automatic t_pol;
        dead_i    = 8'd2;
        pol_top_i = 1'b1;
        pol_bot_i = 1'b1;
        tick(1);
        chk("R7 bottom active low", 2'b10);
        ref_a_i = 1'b1;
        for (int i = 0; i < 2; i++) begin
            tick(1);
            chk("R7 gap reads high", 2'b11);
        end
        tick(1);
        chk("R7 top active low", 2'b01);
        pol_top_i = 1'b0;
        pol_bot_i = 1'b0;
        ref_a_i   = 1'b0;
        tick(3);
        chk("R7 back to normal", 2'b01);
    endtask

    task automatic t_indep;
        indep_i = 1'b1;
        ref_a_i = 1'b1;
        ref_b_i = 1'b1;
        tick(1);
        chk("R6 both active", 2'b11);
        ref_a_i = 1'b0;
        tick(1);
        chk("R6 top follows a", 2'b01);
        ref_a_i = 1'b1;
        ref_b_i = 1'b0;
        tick(1);
        chk("R6 bottom follows b", 2'b10);
    endtask

    task automatic t_leave;
        dead_i  = 8'd2;
        indep_i = 1'b0;
        for (int i = 0; i < 2; i++) begin
            tick(1);
            chk("R9 gap on mode exit", 2'b00);
        end
        tick(1);
        chk("R9 top after exit", 2'b10);
    endtask

    task automatic t_corr;
        dead_i     = 8'd0;
        ref_a_i    = 1'b1;
        ref_b_i    = 1'b0;
        corr_src_i = 1'b0;
        corr_sw_i  = 1'b0;
        corr_cs_i  = 1'b1;
        tick(1);
        chk("R8 sw=0 picks a", 2'b10);
        corr_sw_i = 1'b1;
        corr_cs_i = 1'b0;
        tick(1);
        chk("R8 sw=1 picks b", 2'b01);
        corr_src_i = 1'b1;
        tick(1);
        chk("R8 cs=0 picks a, sw ignored", 2'b10);
        corr_cs_i = 1'b1;
        corr_sw_i = 1'b0;
        tick(1);
        chk("R8 cs=1 picks b, sw ignored", 2'b01);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_deadtime();
        t_short();
        t_zero();
        t_pol();
        t_indep();
        t_leave();
        t_corr();
        tick(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule